// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Pending, Priority and Vector Unit

This block holds the interrupt state of a two-channel serial controller. Each channel (A and B) has three interrupt sources: receive, transmit and external/status. The external/status source is raised when the channel's clear-to-send level changes. Each source can be enabled through a write to that channel's enable register. A source that is both enabled and strobed becomes pending, and it stays pending until a reset command or the removal of its enable clears it.

The six pending bits are resolved by a fixed priority. The block drives an interrupt request, gated by the master-control value. It also drives an 8-bit vector made from a vector base, into which the winning source can be encoded in either the low bits or the high nibble. The vector is combinational, so an acknowledge cycle can take it in the same cycle.

All inputs are plain register values or single-cycle strobes. No data stream passes through the block, so no port carries valid/ready and the block applies no back-pressure. A strobe is consumed in the cycle it is high.

Top module: `sio_irq_vec_unit`

## Requirements
- R1: The pending byte maps channel A receive, transmit and external/status to bits 5, 4 and 3, and channel B receive, transmit and external/status to bits 2, 1 and 0. Bits 7:6 always read zero. After reset all pending bits, all enables and `irq` are zero.
- R2: An enable write (`ien_wr`, with `ien_ch` 0 = A and 1 = B) sets the channel's external/status enable from data bit 0, its transmit enable from bit 1, and its receive enable from bit 3 OR bit 4. The new enables take effect at the clock edge of the write. A strobe to a source that is not enabled is ignored.
- R3: When an enable write clears a source's enable, that source's pending bit is cleared at the same edge.
- R4: A high `rx_evt[c]` or `tx_evt[c]` on an enabled source sets its pending bit at the next edge. The bit then stays set while no clear applies to it.
- R5: The external/status pending bit of channel c is set at the next edge whenever `cts_in[c]` differs from its value in the previous cycle, provided the source is enabled. The sampled level is zero after reset.
- R6: A command with `cmd_code` = 3'b111, from either channel, clears the single highest-priority pending bit. Priority falls from bit 5 down to bit 0.
- R7: A command with `cmd_code` = 3'b101 clears the issuing channel's transmit pending bit, and `cmd_code` = 3'b010 clears the issuing channel's external/status pending bit. All other codes have no effect. A strobe in the same cycle as a clear of the same bit leaves that bit set.
- R8: `irq` is high exactly when some pending bit is set and `mctl[3]`=1, `mctl[1]`=0 and `mctl[0]`=1.
- R9: When `mctl[1:0]` is 2'b00, `vec` equals `vbase`.
- R10: When `mctl[1:0]` is nonzero and `mctl[4]`=0, `vec` is `vbase` with bits 3:1 replaced by the winner's code. As full-byte values these codes are: A receive 0xC, A transmit 0x8, A external 0xA, B receive 0x4, B transmit 0x0, B external 0x2, nothing pending 0x6.
- R11: When `mctl[1:0]` is nonzero and `mctl[4]`=1, `vec` is `vbase` with bits 6:4 replaced by the winner's code. As full-byte values these codes are: A receive 0x30, A transmit 0x10, A external 0x50, B receive 0x20, B transmit 0x00, B external 0x40, nothing pending 0x60.
- R12: `vec` and `irq` follow changes of `mctl` and `vbase` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_wr | input | 1 | Enable-register write strobe |
| ien_ch | input | 1 | Channel of the enable write (0 = A, 1 = B) |
| ien_data | input | 8 | Enable-register write data |
| mctl | input | 8 | Master-control register value |
| vbase | input | 8 | Vector base register value |
| cmd_vld | input | 1 | Reset-command strobe |
| cmd_ch | input | 1 | Channel issuing the command |
| cmd_code | input | 3 | Command field (command register bits 5:3) |
| rx_evt | input | 2 | Receive event strobes, index 0 = A |
| tx_evt | input | 2 | Transmit event strobes, index 0 = A |
| cts_in | input | 2 | Clear-to-send levels, index 0 = A |
| pend | output | 8 | Pending byte |
| irq | output | 1 | Interrupt request |
| vec | output | 8 | Interrupt vector |

## Verification
The bench targets several corner cases:
- A highest-reset issued while several bits are pending. A wrong priority order would clear a lower bit and leave the vector stuck on the old winner.
- Transmit and external/status clears issued from the opposite channel. A design that ignored the issuing channel would clear the wrong bank.
- Strobes that coincide with a clear, and enable writes that drop a source while it is pending. A wrong design would either lose the event or leave a pending bit that can no longer be acknowledged.
- Both code tables with nothing pending, and master-control values with bit 1 set. A mistake here shows up as a wrong vector nibble or as a request that fires while the vector logic is configured otherwise.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int CH_NUM     = 2;
  localparam int SRC_PER_CH = 3;
  localparam int SRC_NUM    = CH_NUM * SRC_PER_CH;
  localparam int CODE_W     = 3;

  // command field values
  localparam logic [2:0] CMD_CLR_EXT  = 3'b010;
  localparam logic [2:0] CMD_CLR_TX   = 3'b101;
  localparam logic [2:0] CMD_CLR_HIGH = 3'b111;

  // local source order inside one channel bank
  localparam int SRC_EXT = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_RX  = 2;

  // code placed at vector bits 3:1 for a one-hot winner
  function automatic logic [CODE_W-1:0] low_code(input logic [SRC_NUM-1:0] win);
    logic [CODE_W-1:0] c;
    case (win)
      6'b100000: c = 3'b110;
      6'b010000: c = 3'b100;
      6'b001000: c = 3'b101;
      6'b000100: c = 3'b010;
      6'b000010: c = 3'b000;
      6'b000001: c = 3'b001;
      default:   c = 3'b011;
    endcase
    return c;
  endfunction

  // the high-nibble table is the low table with its bit order reversed
  function automatic logic [CODE_W-1:0] rev_code(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] r;
    for (int i = 0; i < CODE_W; i++) r[i] = c[CODE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
  import sio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_wr,
  input  logic [SRC_PER_CH-1:0] en_bits,
  input  logic                  cmd_here,
  input  logic [2:0]            cmd_code,
  input  logic [SRC_PER_CH-1:0] hi_clr,
  input  logic                  rx_evt,
  input  logic                  tx_evt,
  input  logic                  cts_in,
  output logic [SRC_PER_CH-1:0] en_q,
  output logic [SRC_PER_CH-1:0] pend_q
);
  logic                  cts_q;
  logic [SRC_PER_CH-1:0] en_n;
  logic [SRC_PER_CH-1:0] clr;
  logic [SRC_PER_CH-1:0] evt;
  logic [SRC_PER_CH-1:0] pend_n;

  always_comb begin
    en_n = en_wr ? en_bits : en_q;
    clr  = hi_clr;
    if (cmd_here && cmd_code == CMD_CLR_TX)  clr[SRC_TX]  = 1'b1;
    if (cmd_here && cmd_code == CMD_CLR_EXT) clr[SRC_EXT] = 1'b1;
    evt          = '0;
    evt[SRC_RX]  = rx_evt;
    evt[SRC_TX]  = tx_evt;
    evt[SRC_EXT] = cts_in ^ cts_q;
    // a strobe wins over a clear; a dropped enable removes the bit
    pend_n = ((pend_q & ~clr) | evt) & en_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      cts_q  <= 1'b0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      cts_q  <= cts_in;
    end
  end

  // R3: nothing pends without its enable
  a_r3_pend_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~en_q) == '0);

  // R3: dropping the transmit enable drops its pending bit
  a_r3_drop_tx: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && !en_bits[SRC_TX] |=> !pend_q[SRC_TX] && !en_q[SRC_TX]);

  // R4: receive pending holds unless cleared
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[SRC_RX] && !en_wr && !hi_clr[SRC_RX] |=> pend_q[SRC_RX]);

  // R5: a level change on an enabled source raises external/status
  a_r5_cts_edge: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[SRC_EXT] && !en_wr && (cts_in != cts_q) |=> pend_q[SRC_EXT]);

  // R7: transmit clear without a coinciding strobe
  a_r7_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_here && cmd_code == CMD_CLR_TX && !tx_evt |=> !pend_q[SRC_TX]);
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win,
  output logic         any
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N - 1) begin : g_top
      assign win[i] = req[i];
    end else begin : g_low
      assign win[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end

  assign any = |req;
endmodule

// File: rtl/sio_irq_vfmt.sv
module sio_irq_vfmt
  import sio_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0]   vbase,
  input  logic               stat_en,
  input  logic               stat_hi,
  input  logic [SRC_NUM-1:0] win,
  output logic [VEC_W-1:0]   vec
);
  localparam int LO_POS = 1;
  localparam int HI_POS = 4;

  logic [CODE_W-1:0] code;

  always_comb begin
    code = low_code(win);
    vec  = vbase;
    if (stat_en) begin
      if (stat_hi) vec[HI_POS +: CODE_W] = rev_code(code);
      else         vec[LO_POS +: CODE_W] = code;
    end
  end
endmodule

// File: rtl/sio_irq_vec_unit.sv
module sio_irq_vec_unit
  import sio_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr,
  input  logic             ien_ch,
  input  logic [7:0]       ien_data,
  input  logic [7:0]       mctl,
  input  logic [VEC_W-1:0] vbase,
  input  logic             cmd_vld,
  input  logic             cmd_ch,
  input  logic [2:0]       cmd_code,
  input  logic [1:0]       rx_evt,
  input  logic [1:0]       tx_evt,
  input  logic [1:0]       cts_in,
  output logic [7:0]       pend,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);
  localparam int PAD_W = 8 - SRC_NUM;

  logic [SRC_NUM-1:0]    pend_all;
  logic [SRC_NUM-1:0]    en_all;
  logic [SRC_NUM-1:0]    win;
  logic [SRC_NUM-1:0]    hi_clr;
  logic [SRC_PER_CH-1:0] en_bits;
  logic                  any_pend;
  logic                  irq_gate;
  logic                  unused_bits;

  assign en_bits = {ien_data[4] | ien_data[3], ien_data[1], ien_data[0]};
  assign hi_clr  = (cmd_vld && cmd_code == CMD_CLR_HIGH) ? win : '0;
  assign unused_bits = ^{ien_data[7:5], ien_data[2], mctl[7:5], mctl[2], en_all};

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    localparam int LO = SRC_PER_CH * (CH_NUM - 1 - c);
    localparam logic SEL = 1'(c);
    sio_irq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (ien_wr && ien_ch == SEL),
      .en_bits  (en_bits),
      .cmd_here (cmd_vld && cmd_ch == SEL),
      .cmd_code (cmd_code),
      .hi_clr   (hi_clr[LO +: SRC_PER_CH]),
      .rx_evt   (rx_evt[c]),
      .tx_evt   (tx_evt[c]),
      .cts_in   (cts_in[c]),
      .en_q     (en_all[LO +: SRC_PER_CH]),
      .pend_q   (pend_all[LO +: SRC_PER_CH])
    );
  end

  sio_irq_prio #(.N(SRC_NUM)) u_prio (
    .req (pend_all),
    .win (win),
    .any (any_pend)
  );

  sio_irq_vfmt #(.VEC_W(VEC_W)) u_vfmt (
    .vbase   (vbase),
    .stat_en (mctl[1] | mctl[0]),
    .stat_hi (mctl[4]),
    .win     (win),
    .vec     (vec)
  );

  assign irq_gate = mctl[3] & ~mctl[1] & mctl[0];
  assign irq      = any_pend & irq_gate;
  assign pend     = {{PAD_W{1'b0}}, pend_all};

  // R6: exactly one winner at most, and it is pending
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win) && ((win & ~pend_all) == '0));

  // R6: the old winner is gone after a highest-reset (strobe-free sources)
  a_r6_high_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_code == CMD_CLR_HIGH && rx_evt == 2'b00 && tx_evt == 2'b00
    |=> (pend_all & $past(win) & 6'b110110) == '0);

  // R8: request needs a pending bit and the master gate
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != 8'h00) && mctl[3] && mctl[0] && !mctl[1]);

  // R9: no status field means the base passes through
  a_r9_plain_base: assert property (@(posedge clk) disable iff (!rst_n)
    mctl[1:0] == 2'b00 |-> vec == vbase);

  // R1: unused pending bits stay low
  a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pend[7:6] == 2'b00);
endmodule

// File: tb/test_sio_irq_vec_unit.sv
module test_sio_irq_vec_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ien_wr, ien_ch;
  logic [7:0] ien_data, mctl, vbase;
  logic       cmd_vld, cmd_ch;
  logic [2:0] cmd_code;
  logic [1:0] rx_evt, tx_evt, cts_in;
  logic [7:0] pend, vec;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;

  // reference state: bit index follows the pending byte layout
  bit [5:0] m_en, m_pend;
  bit [1:0] m_cts;

  always #4 clk = ~clk;

  sio_irq_vec_unit i_sio_irq_vec_unit (
    .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_ch(ien_ch), .ien_data(ien_data),
    .mctl(mctl), .vbase(vbase), .cmd_vld(cmd_vld), .cmd_ch(cmd_ch), .cmd_code(cmd_code),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .cts_in(cts_in), .pend(pend), .irq(irq), .vec(vec)
  );

  function automatic int top_bit(bit [5:0] p);
    for (int i = 5; i >= 0; i--) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_vec();
    int h = top_bit(m_pend);
    logic [7:0] v;
    if (mctl[1:0] == 2'b00) return vbase;
    if (mctl[4]) begin
      case (h)
        5: v = 8'h30; 4: v = 8'h10; 3: v = 8'h50;
        2: v = 8'h20; 1: v = 8'h00; 0: v = 8'h40;
        default: v = 8'h60;
      endcase
      return (vbase & 8'h8F) | v;
    end
    case (h)
      5: v = 8'h0C; 4: v = 8'h08; 3: v = 8'h0A;
      2: v = 8'h04; 1: v = 8'h00; 0: v = 8'h02;
      default: v = 8'h06;
    endcase
    return (vbase & 8'hF1) | v;
  endfunction

  task automatic step(input string tag);
    logic [7:0] e_pend, e_vec;
    logic e_irq;
    bit [5:0] n_en, clr, evt;
    int base;
    #1;
    e_pend = {2'b00, m_pend};
    e_irq  = (m_pend != 0) && mctl[3] && !mctl[1] && mctl[0];
    e_vec  = exp_vec();
    n_vec++;
    if (pend !== e_pend || irq !== e_irq || vec !== e_vec) begin
      n_bad++;
      $display("FAIL %s: pend=%h irq=%b vec=%h expected pend=%h irq=%b vec=%h",
               tag, pend, irq, vec, e_pend, e_irq, e_vec);
    end
    // next state from the requirements
    n_en = m_en;
    if (ien_wr) begin
      base = ien_ch ? 0 : 3;
      n_en[base]   = ien_data[0];
      n_en[base+1] = ien_data[1];
      n_en[base+2] = ien_data[3] | ien_data[4];
    end
    clr = '0;
    if (cmd_vld) begin
      base = cmd_ch ? 0 : 3;
      if (cmd_code == 3'b111 && top_bit(m_pend) >= 0) clr[top_bit(m_pend)] = 1'b1;
      if (cmd_code == 3'b101) clr[base+1] = 1'b1;
      if (cmd_code == 3'b010) clr[base] = 1'b1;
    end
    evt = {rx_evt[0], tx_evt[0], cts_in[0] != m_cts[0],
           rx_evt[1], tx_evt[1], cts_in[1] != m_cts[1]};
    @(posedge clk);
    m_pend = ((m_pend & ~clr) | evt) & n_en;
    m_en   = n_en;
    m_cts  = cts_in;
    @(negedge clk);
    ien_wr = 0; cmd_vld = 0; rx_evt = 0; tx_evt = 0;
  endtask

  task automatic ien(input bit ch, input logic [7:0] d);
    ien_wr = 1; ien_ch = ch; ien_data = d;
  endtask

  task automatic cmd(input bit ch, input logic [2:0] c);
    cmd_vld = 1; cmd_ch = ch; cmd_code = c;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ien_wr = 0; ien_ch = 0; ien_data = 0; mctl = 8'h09; vbase = 8'h40;
    cmd_vld = 0; cmd_ch = 0; cmd_code = 0; rx_evt = 0; tx_evt = 0; cts_in = 0;
    m_en = 0; m_pend = 0; m_cts = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1 reset state");
    ien(0, 8'h13);                 step("R2 enable A via bit4");
    rx_evt = 2'b11;                step("R2 B receive not enabled");
    step("R4 A receive held");
    step("R8 irq with mctl 09");
    mctl = 8'h0B;                  step("R8 irq off with bit1");
    mctl = 8'h01;                  step("R8 irq off without bit3");
    mctl = 8'h09; tx_evt = 2'b01;  step("R10 A rx outranks A tx");
    mctl = 8'h19;                  step("R11 high nibble A rx");
    mctl = 8'h08;                  step("R9 plain base");
    mctl = 8'h09; cmd(1, 3'b111);  step("R6 highest reset from B");
    step("R10 A tx now wins");
    cts_in = 2'b01;                step("R5 cts A change");
    mctl = 8'h19;                  step("R11 A tx still wins");
    cmd(0, 3'b101);                step("R7 clear A tx");
    step("R11 A ext wins");
    cmd(1, 3'b010);                step("R7 B clear leaves A ext");
    cmd(0, 3'b010);                step("R7 clear A ext");
    tx_evt = 2'b01; cmd(0, 3'b101); step("R7 strobe beats clear");
    cmd(0, 3'b011);                step("R7 unused code ignored");
    ien(1, 8'h0B);                 step("R2 enable B via bit3");
    rx_evt = 2'b10; tx_evt = 2'b10; cts_in = 2'b11; step("R4 B events");
    ien(0, 8'h00);                 step("R3 drop A enables");
    mctl = 8'h1A; vbase = 8'hFF;   step("R12 same-cycle high B rx");
    mctl = 8'h02; vbase = 8'h00;   step("R12 same-cycle low B rx");
    cmd(0, 3'b111);                step("R6 highest reset from A");
    mctl = 8'h19;                  step("R11 B tx code 00");
    cmd(1, 3'b101);                step("R7 clear B tx");
    mctl = 8'h09;                  step("R10 B ext code");
    cmd(1, 3'b010);                step("R7 clear B ext");
    step("R10 none pending code 6");
    mctl = 8'h11;                  step("R11 none pending code 60");
    ien(1, 8'h08);                 step("R3 drop B tx and ext");
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 7) == 0) ien($urandom_range(0, 1) == 1, 8'($urandom));
      if ($urandom_range(0, 5) == 0) cmd($urandom_range(0, 1) == 1, 3'($urandom));
      rx_evt = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      tx_evt = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      if ($urandom_range(0, 4) == 0) cts_in = 2'($urandom);
      if ($urandom_range(0, 3) == 0) mctl = ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'h09;
      if ($urandom_range(0, 7) == 0) vbase = 8'($urandom);
      step("R4 R6 R8 R10 R11 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule